// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Generator

This block sits beside a bus master that issues 20-bit addresses tagged as memory or IO accesses. For each bus cycle it latches the address, works out which configured range the address falls in, and drives one active-low select line for the length of the cycle. The ranges are a top-of-memory range, a bottom-of-memory range, a mid-memory window split into four equal slices, and a peripheral page split into seven 128-byte slots.

Every range carries its own wait-state count (0 to 3) and a flag that picks how the cycle's ready is formed. The ready is either internal only, or the internal count ANDed with an external ready input. A narrow write port loads the range registers. After reset, only the top range is live: it covers the highest 1 KB with three waits, and its ready is combined with the external ready.

Top module: `csel_wait_unit`

## Requirements
- R1: While `rst_n` is low, every select output is high and `ready_out` is low, in the same cycle that reset is applied.
- R2: After reset the top range is live with register value FFFBH. It selects addresses FFC00H to FFFFFH in memory space, with 3 waits combined with `ext_rdy`. It is rewritten through index 0: bits [15:6] give the first 1 KB page, bit 2 set means ignore `ext_rdy`, and bits [1:0] give the wait count.
- R3: The bottom range (index 1, same field layout, where [15:6] is the last page covered) selects memory addresses from 00000H up to the end of that page. It stays inactive until index 1 has been written.
- R4: The mid window has its base page at index 2 [15:6] and its size code k at index 3 [8:6]. It holds four slices of 1 KB<<k each, and slice n drives `mid_sel_n[n]`. It goes live on the first write to index 3, which also carries bit 2 (ignore) and bits [1:0] (wait count).
- R5: The peripheral page (index 4, base page in [15:6]) drives `per_sel_n[j]` for offset bits [9:7] equal to j, for j from 0 to 6. An offset slot of 7 selects nothing. The page goes live on the first write to index 4.
- R6: Index 4 bit 3 set places the peripheral page in IO space (`bus_io`=1), and clear places it in memory space. The top, bottom and mid ranges respond only when `bus_io`=0.
- R7: With a wait count w, `ready_out` first rises w cycles after the first cycle in which the select is low.
- R8: With the ignore bit clear, `ready_out` additionally requires `ext_rdy` high. With it set, `ext_rdy` has no effect.
- R9: An access that hits no range asserts no select, and `ready_out` follows `ext_rdy` during that cycle.
- R10: `cyc_start` arms the unit, and `addr_valid` while armed latches the address. Selects go low in the next cycle, hold steady until `cyc_end`, and return high in the cycle after `cyc_end`.
- R11: At most one select is low at a time. When ranges overlap, the priority is top, then bottom, then mid, then peripheral.
- R12: Writes to indices 5 to 7 change nothing. A register write during an active cycle does not alter that cycle's select or wait count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 16 | Register write data |
| bus_addr | input | 20 | Bus address |
| bus_io | input | 1 | 1 = IO space, 0 = memory space |
| cyc_start | input | 1 | Bus cycle start |
| addr_valid | input | 1 | Address valid strobe |
| cyc_end | input | 1 | Bus cycle end |
| ext_rdy | input | 1 | External ready |
| hi_sel_n | output | 1 | Top-range select, active low |
| lo_sel_n | output | 1 | Bottom-range select, active low |
| mid_sel_n | output | N_MID | Mid-window slice selects, active low |
| per_sel_n | output | N_PER | Peripheral slot selects, active low |
| ready_out | output | 1 | Cycle ready |

## Verification
A wrong latched range shows up at once, in the first active cycle after `addr_valid`, as the wrong select line going low. A corrupted wait counter or ignore flag shows only in `ready_out`, between one and three cycles later, so the bench compares `ready_out` on every clock while `ext_rdy` is held low for some of those cycles. Stale configuration state appears only on the next access to the affected range, so every register write is followed by accesses on both sides of each range edge.

// File: rtl/csel_pkg.sv
// Shared constants and types for the chip-select unit.
// Assumes a 20-bit byte address and 1 KB range granularity.
package csel_pkg;
    localparam int ADDR_W   = 20;
    localparam int PAGE_LSB = 10;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int CFG_W    = 16;
    localparam int WS_W     = 2;
    localparam int SIZE_W   = 3;
    localparam int IDX_W    = 3;
    localparam int BLK_LSB  = 7;

    typedef struct packed {
        logic              en;
        logic [PAGE_W-1:0] page;
        logic [SIZE_W-1:0] size_k;
        logic              io;
        logic              ign;
        logic [WS_W-1:0]   ws;
    } rng_cfg_t;

    typedef enum logic [IDX_W-1:0] {
        REG_HI    = 3'd0,
        REG_LO    = 3'd1,
        REG_MBASE = 3'd2,
        REG_MCTL  = 3'd3,
        REG_PER   = 3'd4
    } reg_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ACT   = 2'd2
    } seq_st_t;
endpackage

// File: rtl/csel_cfg_regs.sv
// Range configuration registers.
// Only the top range is live out of reset. The others go live on a write to
// their control index. Unknown indices are dropped.
module csel_cfg_regs
    import csel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [CFG_W-1:0] wdata,
    output rng_cfg_t         hi_cfg,
    output rng_cfg_t         lo_cfg,
    output rng_cfg_t         mid_cfg,
    output rng_cfg_t         per_cfg
);
    logic [1:0] cfg_unused;
    assign cfg_unused = wdata[5:4];

    // Register update: reset values, then field loads on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cfg  <= '{en: 1'b1, page: '1, size_k: '0, io: 1'b0, ign: 1'b0, ws: 2'd3};
            lo_cfg  <= '0;
            mid_cfg <= '0;
            per_cfg <= '0;
        end else if (we) begin
            case (idx)
                REG_HI: begin
                    hi_cfg.page <= wdata[CFG_W-1 -: PAGE_W];
                    hi_cfg.ign  <= wdata[2];
                    hi_cfg.ws   <= wdata[WS_W-1:0];
                end
                REG_LO: begin
                    lo_cfg.en   <= 1'b1;
                    lo_cfg.page <= wdata[CFG_W-1 -: PAGE_W];
                    lo_cfg.ign  <= wdata[2];
                    lo_cfg.ws   <= wdata[WS_W-1:0];
                end
                REG_MBASE: mid_cfg.page <= wdata[CFG_W-1 -: PAGE_W];
                REG_MCTL: begin
                    mid_cfg.en     <= 1'b1;
                    mid_cfg.size_k <= wdata[8:6];
                    mid_cfg.ign    <= wdata[2];
                    mid_cfg.ws     <= wdata[WS_W-1:0];
                end
                REG_PER: begin
                    per_cfg.en   <= 1'b1;
                    per_cfg.page <= wdata[CFG_W-1 -: PAGE_W];
                    per_cfg.io   <= wdata[3];
                    per_cfg.ign  <= wdata[2];
                    per_cfg.ws   <= wdata[WS_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/csel_decode.sv
// Combinational address decoder.
// It picks at most one select, in the order top, bottom, mid, peripheral, and
// returns that range's wait count and ready mode.
// Assumes N_PER slots of 128 bytes fit in one 1 KB page.
module csel_decode
    import csel_pkg::*;
#(
    parameter int N_MID = 4,
    parameter int N_PER = 7,
    localparam int NSEL    = 2 + N_MID + N_PER,
    localparam int SEL_MID = 2,
    localparam int SEL_PER = 2 + N_MID,
    localparam int MID_IW  = $clog2(N_MID),
    localparam int PER_IW  = $clog2(N_PER)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io,
    input  rng_cfg_t          hi_cfg,
    input  rng_cfg_t          lo_cfg,
    input  rng_cfg_t          mid_cfg,
    input  rng_cfg_t          per_cfg,
    output logic [NSEL-1:0]   sel,
    output logic              hit,
    output logic              ign,
    output logic [WS_W-1:0]   ws
);
    logic [ADDR_W-1:0] mid_off, mid_sub, per_off, per_blk;
    logic hi_hit, lo_hit, mid_hit, per_hit;
    logic dec_unused;

    assign dec_unused = ^{hi_cfg.size_k, hi_cfg.io, lo_cfg.size_k, lo_cfg.io,
                          mid_cfg.io, per_cfg.size_k};

    // Per-range hit terms
    always_comb begin
        mid_off = addr - {mid_cfg.page, {PAGE_LSB{1'b0}}};
        mid_sub = mid_off >> (PAGE_LSB + int'(mid_cfg.size_k));
        per_off = addr - {per_cfg.page, {PAGE_LSB{1'b0}}};
        per_blk = per_off >> BLK_LSB;
        hi_hit  = hi_cfg.en && !io && (addr[ADDR_W-1 -: PAGE_W] >= hi_cfg.page);
        lo_hit  = lo_cfg.en && !io && (addr[ADDR_W-1 -: PAGE_W] <= lo_cfg.page);
        mid_hit = mid_cfg.en && !io && (mid_sub < ADDR_W'(N_MID));
        per_hit = per_cfg.en && (io == per_cfg.io) && (per_blk < ADDR_W'(N_PER));
    end

    // Priority pick of one select and its ready settings
    always_comb begin
        sel = '0;
        hit = 1'b0;
        ign = 1'b0;
        ws  = '0;
        if (hi_hit) begin
            sel[0] = 1'b1; hit = 1'b1; ign = hi_cfg.ign; ws = hi_cfg.ws;
        end else if (lo_hit) begin
            sel[1] = 1'b1; hit = 1'b1; ign = lo_cfg.ign; ws = lo_cfg.ws;
        end else if (mid_hit) begin
            sel[SEL_MID + int'(mid_sub[MID_IW-1:0])] = 1'b1;
            hit = 1'b1; ign = mid_cfg.ign; ws = mid_cfg.ws;
        end else if (per_hit) begin
            sel[SEL_PER + int'(per_blk[PER_IW-1:0])] = 1'b1;
            hit = 1'b1; ign = per_cfg.ign; ws = per_cfg.ws;
        end
    end
endmodule

// File: rtl/csel_seq.sv
// Bus-cycle sequencer and wait-state counter.
// The decode is latched when addr_valid arrives in the armed state. The
// latched select is held until cyc_end, and the wait count runs down to zero.
module csel_seq
    import csel_pkg::*;
#(
    parameter int NSEL = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_start,
    input  logic            addr_valid,
    input  logic            cyc_end,
    input  logic            ext_rdy,
    input  logic [NSEL-1:0] dec_sel,
    input  logic            dec_hit,
    input  logic            dec_ign,
    input  logic [WS_W-1:0] dec_ws,
    output logic [NSEL-1:0] sel_q,
    output logic            rdy
);
    seq_st_t         state;
    logic [WS_W-1:0] cnt;
    logic            hit_q, ign_q;

    // Cycle state, latched decode and wait countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= '0;
            cnt   <= '0;
            hit_q <= 1'b0;
            ign_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (cyc_start) state <= ST_ARMED;
                ST_ARMED: if (addr_valid) begin
                    state <= ST_ACT;
                    sel_q <= dec_sel;
                    hit_q <= dec_hit;
                    ign_q <= dec_ign;
                    cnt   <= dec_ws;
                end
                ST_ACT: begin
                    if (cyc_end) begin
                        state <= ST_IDLE;
                        sel_q <= '0;
                    end else if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Ready: internal count, optionally ANDed with external ready
    assign rdy = rst_n && (state == ST_ACT) &&
                 (hit_q ? ((cnt == '0) && (ign_q || ext_rdy)) : ext_rdy);
endmodule

// File: rtl/csel_wait_unit.sv
// Top level of the chip-select and wait-state generator.
// All selects are forced high while rst_n is low, without waiting for a clock
// edge.
module csel_wait_unit
    import csel_pkg::*;
#(
    parameter int N_MID = 4,
    parameter int N_PER = 7,
    localparam int NSEL = 2 + N_MID + N_PER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_io,
    input  logic              cyc_start,
    input  logic              addr_valid,
    input  logic              cyc_end,
    input  logic              ext_rdy,
    output logic              hi_sel_n,
    output logic              lo_sel_n,
    output logic [N_MID-1:0]  mid_sel_n,
    output logic [N_PER-1:0]  per_sel_n,
    output logic              ready_out
);
    rng_cfg_t        hi_cfg, lo_cfg, mid_cfg, per_cfg;
    logic [NSEL-1:0] dec_sel, sel_q, sel_n;
    logic            dec_hit, dec_ign;
    logic [WS_W-1:0] dec_ws;

    csel_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
        .hi_cfg(hi_cfg), .lo_cfg(lo_cfg), .mid_cfg(mid_cfg), .per_cfg(per_cfg)
    );

    csel_decode #(.N_MID(N_MID), .N_PER(N_PER)) u_dec (
        .addr(bus_addr), .io(bus_io),
        .hi_cfg(hi_cfg), .lo_cfg(lo_cfg), .mid_cfg(mid_cfg), .per_cfg(per_cfg),
        .sel(dec_sel), .hit(dec_hit), .ign(dec_ign), .ws(dec_ws)
    );

    csel_seq #(.NSEL(NSEL)) u_seq (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .addr_valid(addr_valid),
        .cyc_end(cyc_end), .ext_rdy(ext_rdy), .dec_sel(dec_sel), .dec_hit(dec_hit),
        .dec_ign(dec_ign), .dec_ws(dec_ws), .sel_q(sel_q), .rdy(ready_out)
    );

    // Active-low outputs, held inactive during reset
    assign sel_n     = ~sel_q | {NSEL{~rst_n}};
    assign hi_sel_n  = sel_n[0];
    assign lo_sel_n  = sel_n[1];
    assign mid_sel_n = sel_n[2 +: N_MID];
    assign per_sel_n = sel_n[2 + N_MID +: N_PER];
endmodule

// File: rtl/csel_wait_unit_chk.sv
// Port-level property checker for csel_wait_unit, attached by bind.
module csel_wait_unit_chk #(
    parameter int N_MID = 4,
    parameter int N_PER = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_valid,
    input logic             cyc_end,
    input logic             hi_sel_n,
    input logic             lo_sel_n,
    input logic [N_MID-1:0] mid_sel_n,
    input logic [N_PER-1:0] per_sel_n
);
    logic [1+1+N_MID+N_PER-1:0] all_n;
    assign all_n = {per_sel_n, mid_sel_n, lo_sel_n, hi_sel_n};

    // R1
    always @(negedge clk) if (rst_n == 1'b0) begin
        sel_in_reset_chk: assert (&all_n);
    end

    // R11
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~all_n));

    // R10
    sel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&all_n) |-> $past(addr_valid));

    // R10
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&all_n) && !cyc_end) |=> $stable(all_n));

    // R10
    sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&all_n) && cyc_end) |=> (&all_n));
endmodule

bind csel_wait_unit csel_wait_unit_chk #(.N_MID(N_MID), .N_PER(N_PER)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .cyc_end(cyc_end),
    .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n), .mid_sel_n(mid_sel_n),
    .per_sel_n(per_sel_n)
);

// File: tb/csel_wait_unit_test.sv
module csel_wait_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic [19:0] bus_addr = '0;
    logic        bus_io = 1'b0;
    logic        cyc_start = 1'b0, addr_valid = 1'b0, cyc_end = 1'b0;
    logic        ext_rdy = 1'b1;
    logic        hi_sel_n, lo_sel_n, ready_out;
    logic [3:0]  mid_sel_n;
    logic [6:0]  per_sel_n;

    int    checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_state = 0, m_sel = -1, m_cnt = 0;
    bit m_ign = 0, m_hit = 0;
    int hi_page, lo_page, mid_page, mid_k, per_page;
    bit lo_en, mid_en, per_en, per_io;
    int ws_r[4];
    bit ign_r[4];

    csel_wait_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_io(bus_io),
        .cyc_start(cyc_start), .addr_valid(addr_valid), .cyc_end(cyc_end),
        .ext_rdy(ext_rdy), .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n),
        .mid_sel_n(mid_sel_n), .per_sel_n(per_sel_n), .ready_out(ready_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // select number: 0 top, 1 bottom, 2..5 mid, 6..12 peripheral, -1 none
    function automatic int ref_pick(int a, bit io);
        int span, mb, pb;
        if (!io && a >= hi_page * 1024) return 0;
        if (!io && lo_en && a < (lo_page + 1) * 1024) return 1;
        span = 1024 << mid_k;
        mb = mid_page * 1024;
        if (!io && mid_en && a >= mb && a < mb + 4 * span) return 2 + (a - mb) / span;
        pb = per_page * 1024;
        if (per_en && io == per_io && a >= pb && a < pb + 7 * 128) return 6 + (a - pb) / 128;
        return -1;
    endfunction

    function automatic int grp(int s);
        if (s < 2) return s;
        if (s < 6) return 2;
        return 3;
    endfunction

    task automatic model_reset();
        hi_page = 1023; ws_r[0] = 3; ign_r[0] = 0;
        lo_en = 0; mid_en = 0; per_en = 0; per_io = 0;
        lo_page = 0; mid_page = 0; mid_k = 0; per_page = 0;
        for (int i = 1; i < 4; i++) begin ws_r[i] = 0; ign_r[i] = 0; end
        m_state = 0; m_sel = -1; m_cnt = 0; m_ign = 0; m_hit = 0;
    endtask

    // model update at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) model_reset();
        else begin
            case (m_state)
                0: if (cyc_start) m_state = 1;
                1: if (addr_valid) begin
                    m_sel = ref_pick(int'(bus_addr), bus_io);
                    m_hit = (m_sel >= 0);
                    m_cnt = m_hit ? ws_r[grp(m_sel)] : 0;
                    m_ign = m_hit ? ign_r[grp(m_sel)] : 0;
                    m_state = 2;
                end
                default: if (cyc_end) begin m_state = 0; m_sel = -1; end
                         else if (m_cnt > 0) m_cnt--;
            endcase
            if (cfg_we) begin
                case (cfg_idx)
                    3'd0: begin hi_page = int'(cfg_wdata[15:6]); ign_r[0] = cfg_wdata[2]; ws_r[0] = int'(cfg_wdata[1:0]); end
                    3'd1: begin lo_en = 1; lo_page = int'(cfg_wdata[15:6]); ign_r[1] = cfg_wdata[2]; ws_r[1] = int'(cfg_wdata[1:0]); end
                    3'd2: mid_page = int'(cfg_wdata[15:6]);
                    3'd3: begin mid_en = 1; mid_k = int'(cfg_wdata[8:6]); ign_r[2] = cfg_wdata[2]; ws_r[2] = int'(cfg_wdata[1:0]); end
                    3'd4: begin per_en = 1; per_page = int'(cfg_wdata[15:6]); per_io = cfg_wdata[3]; ign_r[3] = cfg_wdata[2]; ws_r[3] = int'(cfg_wdata[1:0]); end
                    default: ;
                endcase
            end
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected < 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        logic [12:0] exp_n, act_n;
        logic        exp_r;
        exp_n = '1;
        if (rst_n && m_state == 2 && m_sel >= 0) exp_n[m_sel] = 1'b0;
        exp_r = rst_n && (m_state == 2) &&
                (m_hit ? (m_cnt == 0 && (m_ign || ext_rdy)) : ext_rdy);
        act_n = {per_sel_n, mid_sel_n, lo_sel_n, hi_sel_n};
        checks += 2;
        if (act_n !== exp_n) begin
            errors++;
            $display("FAIL %s selects: actual %b expected %b", cur_req, act_n, exp_n);
        end
        if (ready_out !== exp_r) begin
            errors++;
            $display("FAIL %s ready: actual %b expected %b", cur_req, ready_out, exp_r);
        end
    end

    task automatic wr(input int idx, input int d);
        @(posedge clk); #2;
        cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = 16'(d);
        @(posedge clk); #2;
        cfg_we = 0;
    endtask

    // one bus cycle; ext_rdy held low for lo_cyc active cycles; optional write mid-cycle
    task automatic bus(input int a, input bit io, input int lo_cyc, input bit poke);
        @(posedge clk); #2; cyc_start = 1;
        @(posedge clk); #2; cyc_start = 0; bus_addr = 20'(a); bus_io = io; addr_valid = 1;
        @(posedge clk); #2; addr_valid = 0; ext_rdy = (lo_cyc == 0);
        if (poke) begin cfg_we = 1; cfg_idx = 3'd0; cfg_wdata = 16'hFFC4; end
        for (int i = 1; i <= 5; i++) begin
            @(posedge clk); #2;
            cfg_we = 0;
            if (i >= lo_cyc) ext_rdy = 1;
        end
        cyc_end = 1;
        @(posedge clk); #2; cyc_end = 0; ext_rdy = 1;
    endtask

    initial begin
        model_reset();
        cur_req = "R1";
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        cur_req = "R2"; bus('hFFC00, 0, 2, 0); bus('hFFFFF, 0, 0, 0);
        cur_req = "R9"; bus('hFFBFF, 0, 0, 0); bus('h12345, 0, 3, 0);
        cur_req = "R10";
        @(posedge clk); #2; addr_valid = 1; bus_addr = 20'hFFC10;
        @(posedge clk); #2; addr_valid = 0;
        repeat (3) @(posedge clk);
        cur_req = "R3"; bus('h00100, 0, 0, 0);
        wr(1, 'h0FC5);
        bus('h01234, 0, 0, 0); bus('h0FFFF, 0, 0, 0); bus('h10000, 0, 0, 0);
        cur_req = "R8"; bus('h01234, 0, 4, 0);
        cur_req = "R4"; wr(2, 'h2000); bus('h20000, 0, 0, 0);
        wr(3, 'h0042);
        bus('h20000, 0, 0, 0); bus('h20800, 0, 0, 0); bus('h21000, 0, 1, 0);
        bus('h21FFF, 0, 0, 0); bus('h22000, 0, 0, 0); bus('h1FFFF, 0, 0, 0);
        cur_req = "R5"; wr(4, 'h0048);
        bus('h00400, 1, 0, 0); bus('h00480, 1, 0, 0); bus('h00700, 1, 0, 0);
        bus('h00780, 1, 0, 0); bus('h003FF, 1, 0, 0);
        cur_req = "R6"; bus('h00400, 0, 0, 0); bus('hFFC00, 1, 0, 0);
        cur_req = "R11"; wr(4, 'h0043); bus('h00400, 0, 0, 0);
        wr(2, 'h0000); bus('h00800, 0, 0, 0); bus('h10000, 0, 0, 0);
        cur_req = "R7";
        for (int w = 0; w < 4; w++) begin
            wr(0, 'hFFC0 + w); bus('hFFE00, 0, 0, 0);
        end
        wr(4, 'h4001); bus('h40000, 0, 2, 0); bus('h40380, 0, 0, 0);
        cur_req = "R8"; wr(4, 'h4006); bus('h40100, 0, 5, 0);
        cur_req = "R12"; wr(0, 'hFFC3);
        wr(5, 'h0000); wr(6, 'hFFFF); wr(7, 'h1234);
        bus('hFFC00, 0, 2, 1); bus('hFFC00, 0, 3, 0);
        cur_req = "R1";
        @(posedge clk); #2; cyc_start = 1;
        @(posedge clk); #2; cyc_start = 0; bus_addr = 20'hFFC00; addr_valid = 1;
        @(posedge clk); #2; addr_valid = 0; rst_n = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        cur_req = "R2"; bus('h00400, 0, 0, 0); bus('hFFC00, 0, 1, 0);
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule